// File: doc/BRIEF.md
# Parallel BCH Stream Encoder

This block is a systematic encoder for binary BCH codes. Message bits arrive on a streaming input, a parameter number of bits per clock. They leave on the output unchanged, and the parity bits follow them. Parity is the remainder of the shifted message polynomial divided by a generator polynomial, which is supplied as a parameter. A feedback register computes it and applies one beat's worth of serial division steps in each clock.

Both sides use a valid/ready style handshake with start and end markers. The upstream side is stalled for exactly the parity phase. The downstream side can stall the output at any beat. Shortened codes are supported: the leading message bits that are left out are taken as zeros.

Top module: `bch_stream_enc`

## Requirements
- R1: Each codeword on `data_out` begins with the K message bits, unchanged and in arrival order. The earliest bit of each beat is on bit DW-1.
- R2: After the message, P = N-K parity bits follow in P/DW beats, highest coefficient first. They equal the remainder of m(x)·x^P modulo g(x). The whole N-bit codeword is therefore divisible by g(x).
- R3: A beat accepted with `sop_in` high starts a new remainder from zero, so no packet depends on the one before it.
- R4: After K/DW-1 message beats have been accepted, `ready` goes low. The final message beat is still taken on a rising edge with `load` high, as long as the output stage is able to advance.
- R5: While parity is being emitted, `load` has no effect. Beats presented during that phase change neither the output nor the next codeword.
- R6: With no downstream stall, `ready` stays low for exactly P/DW sample cycles after the final message beat is taken. It is high in the next cycle.
- R7: `sop_out` is high only on the first beat of a codeword. `eop_out` is high only on its last parity beat. Neither is ever high without `valid_out`.
- R8: While `valid_out` is high and `sink_ready` is low, the output beat and its markers stay unchanged.
- R9: `valid_out` is low whenever no beat is pending.
- R10: A shortened code (K below 2^m-1-P) produces the same parity as the full-length code fed with the same message after leading zeros. For example, with g(x)=x^8+x^7+x^6+x^4+1, the message ...0001 gives parity 0xD1, ...0010 gives 0x73 and ...0100 gives 0xE6.
- R11: A synchronous active-high `rst` empties the output stage (`valid_out` low) and returns the block to the message phase with `ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Input beat valid |
| sop_in | input | 1 | Marks the first message beat |
| eop_in | input | 1 | Marks the last message beat |
| data_in | input | DW | Message bits, earliest bit in the MSB |
| ready | output | 1 | Encoder can take a non-final message beat |
| sink_ready | input | 1 | Downstream accepts the current output beat |
| valid_out | output | 1 | Output beat valid |
| sop_out | output | 1 | First beat of a codeword |
| eop_out | output | 1 | Last beat of a codeword |
| data_out | output | DW | Codeword bits |

## Verification
The bench builds the block with DW=2, N=14 and K=6: a 3-beat message followed by 4 parity beats, using the (15,7) generator shortened by one bit. Because the width is two bits, each cycle's division is unrolled over two steps. The shortening brings R10 within reach, and it can be checked against hand-derived remainders of powers of x. The short frames leave enough room for random load gaps and random sink stalls to land on every beat position, including the final message beat while ready is low.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

    typedef enum logic {
        PH_MSG = 1'b0,
        PH_PAR = 1'b1
    } phase_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bch_in_ctrl.sv
module bch_in_ctrl
    import bch_enc_pkg::*;
#(
    parameter int unsigned MSG_BEATS = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic adv,
    input  logic par_done,
    output logic ready,
    output logic take,
    output logic take_last,
    output phase_e phase
);
    localparam int unsigned CW = cnt_width(MSG_BEATS);
    localparam logic [CW-1:0] LAST = CW'(MSG_BEATS - 1);

    logic [CW-1:0] cnt;

    assign take      = load && (phase == PH_MSG) && adv;
    assign take_last = take && (cnt == LAST);
    assign ready     = (phase == PH_MSG) && adv && (cnt != LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= PH_MSG;
        end else if (take_last) begin
            cnt   <= '0;
            phase <= PH_PAR;
        end else if (take) begin
            cnt <= cnt + 1'b1;
        end else if (par_done) begin
            phase <= PH_MSG;
        end
    end

    // R4
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        take_last |=> !ready);

endmodule

// File: rtl/bch_par_lfsr.sv
module bch_par_lfsr #(
    parameter int unsigned DW        = 1,
    parameter int unsigned PAR       = 8,
    parameter logic [PAR-1:0] GPOLY  = 8'hD1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          sop,
    input  logic [DW-1:0] din,
    input  logic          shift,
    output logic [DW-1:0] top_bits,
    output logic          par_last
);
    localparam int unsigned PAR_BEATS = PAR / DW;
    localparam int unsigned PW = bch_enc_pkg::cnt_width(PAR_BEATS);
    localparam logic [PW-1:0] PLAST = PW'(PAR_BEATS - 1);

    logic [PAR-1:0] rem;
    logic [PW-1:0]  pcnt;

    function automatic logic [PAR-1:0] div_steps(input logic [PAR-1:0] s,
                                                 input logic [DW-1:0] d);
        logic [PAR-1:0] r;
        logic fb;
        r = s;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = d[i] ^ r[PAR-1];
            r  = {r[PAR-2:0], 1'b0} ^ ({PAR{fb}} & GPOLY);
        end
        return r;
    endfunction

    assign top_bits = rem[PAR-1 -: DW];
    assign par_last = (pcnt == PLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            pcnt <= '0;
        end else if (take) begin
            rem  <= div_steps(sop ? '0 : rem, din);
            pcnt <= '0;
        end else if (shift) begin
            rem  <= rem << DW;
            pcnt <= par_last ? '0 : pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/bch_out_reg.sv
module bch_out_reg #(
    parameter int unsigned DW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sink_ready,
    input  logic          load_en,
    input  logic [DW-1:0] d,
    input  logic          sop,
    input  logic          eop,
    output logic          adv,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          sop_o,
    output logic          eop_o
);
    assign adv = !valid || sink_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
            sop_o <= 1'b0;
            eop_o <= 1'b0;
        end else if (adv) begin
            valid <= load_en;
            data  <= d;
            sop_o <= sop && load_en;
            eop_o <= eop && load_en;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !sink_ready) |=> (valid && $stable(data) && $stable(sop_o) && $stable(eop_o)));

    // R7
    marker_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (sop_o || eop_o) |-> valid);

    // R7
    frame_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && eop_o && sink_ready) |=> (!valid || sop_o));

endmodule

// File: rtl/bch_stream_enc.sv
module bch_stream_enc
    import bch_enc_pkg::*;
#(
    parameter int unsigned DW          = 1,
    parameter int unsigned N           = 15,
    parameter int unsigned K           = 7,
    parameter int unsigned PAR         = N - K,
    parameter logic [PAR-1:0] GPOLY    = 8'hD1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          sop_in,
    input  logic          eop_in,
    input  logic [DW-1:0] data_in,
    output logic          ready,
    input  logic          sink_ready,
    output logic          valid_out,
    output logic          sop_out,
    output logic          eop_out,
    output logic [DW-1:0] data_out
);
    localparam int unsigned MSG_BEATS = K / DW;

    if ((K % DW) != 0 || (PAR % DW) != 0 || (N != K + PAR) || PAR < 2) begin : g_bad_cfg
        $error("bch_stream_enc: K and PAR must be multiples of DW, N must equal K+PAR");
    end

    logic   adv, take, take_last, shift, par_last, par_done;
    phase_e phase;
    logic [DW-1:0] top_bits;

    assign shift    = (phase == PH_PAR) && adv;
    assign par_done = shift && par_last;

    bch_in_ctrl #(.MSG_BEATS(MSG_BEATS)) u_ctrl (
        .clk(clk), .rst(rst), .load(load), .adv(adv), .par_done(par_done),
        .ready(ready), .take(take), .take_last(take_last), .phase(phase)
    );

    bch_par_lfsr #(.DW(DW), .PAR(PAR), .GPOLY(GPOLY)) u_lfsr (
        .clk(clk), .rst(rst), .take(take), .sop(sop_in), .din(data_in),
        .shift(shift), .top_bits(top_bits), .par_last(par_last)
    );

    bch_out_reg #(.DW(DW)) u_out (
        .clk(clk), .rst(rst), .sink_ready(sink_ready),
        .load_en(take || shift),
        .d(take ? data_in : top_bits),
        .sop(take && sop_in),
        .eop(par_done),
        .adv(adv), .valid(valid_out), .data(data_out),
        .sop_o(sop_out), .eop_o(eop_out)
    );

    // R5
    par_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        take_last |=> !take);

endmodule

// File: tb/bch_stream_enc_tb_top.sv
module bch_stream_enc_tb_top;
    localparam int unsigned DW = 2;
    localparam int unsigned N  = 14;
    localparam int unsigned K  = 6;
    localparam int unsigned P  = 8;
    localparam logic [7:0]  G  = 8'hD1;
    localparam int NV = 10;

    // message, mode (bit0 gaps, bit1 stalls), expected parity (bit 8 = known)
    localparam logic [5:0] VEC_MSG  [NV] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h08, 6'h3F, 6'h2A, 6'h15, 6'h31};
    localparam logic [1:0] VEC_MODE [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd3, 2'd2, 2'd1, 2'd3};
    localparam logic [8:0] VEC_PAR  [NV] = '{9'h100, 9'h1D1, 9'h173, 9'h1A2, 9'h1E6, 9'h11D, 9'h000, 9'h000, 9'h000, 9'h000};

    logic clk = 1'b0, rst = 1'b1;
    logic load = 1'b0, sop_in = 1'b0, eop_in = 1'b0, sink_ready = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic ready, valid_out, sop_out, eop_out;
    logic [DW-1:0] data_out;

    int n_checks = 0, n_errs = 0;
    int tx_pkts = 0, rx_pkts = 0, rx_beat = 0;
    bit stall_en = 1'b0, done = 1'b0;
    logic [5:0] exp_msg [64];
    logic [7:0] exp_par [64];
    logic [13:0] rx_bits;
    logic hold_pend = 1'b0;
    logic [DW+1:0] hold_val;

    always #10 clk = ~clk;

    bch_stream_enc #(.DW(DW), .N(N), .K(K), .PAR(P), .GPOLY(G)) dut_i (
        .clk(clk), .rst(rst), .load(load), .sop_in(sop_in), .eop_in(eop_in),
        .data_in(data_in), .ready(ready), .sink_ready(sink_ready),
        .valid_out(valid_out), .sop_out(sop_out), .eop_out(eop_out), .data_out(data_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_rem(input logic [6:0] m7);
        logic [7:0] r;
        logic fb;
        r = '0;
        for (int i = 6; i >= 0; i--) begin
            fb = m7[i] ^ r[7];
            r  = {r[6:0], 1'b0} ^ (fb ? G : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [7:0] cw_rem(input logic [13:0] c);
        logic [7:0] r;
        logic fb;
        r = '0;
        for (int i = 13; i >= 0; i--) begin
            fb = r[7];
            r  = {r[6:0], c[i]} ^ (fb ? G : 8'h00);
        end
        return r;
    endfunction

    always @(negedge clk) sink_ready <= stall_en ? (($urandom % 3) != 0) : 1'b1;

    // output monitor, samples 5 ns after the falling edge
    always begin
        @(negedge clk);
        #5;
        if (rst) begin
            rx_beat   = 0;
            hold_pend = 1'b0;
        end else begin
            if (hold_pend)
                chk(valid_out && ({data_out, sop_out, eop_out} == hold_val), "R8 held beat",
                    {valid_out, data_out, sop_out, eop_out}, {1'b1, hold_val});
            hold_pend = valid_out && !sink_ready;
            hold_val  = {data_out, sop_out, eop_out};
            if (!valid_out)
                chk(!sop_out && !eop_out, "R7 markers without valid", {sop_out, eop_out}, 0);
            if (valid_out && sink_ready) begin
                chk(sop_out == (rx_beat == 0), "R7 sop_out position", sop_out, rx_beat == 0);
                chk(eop_out == (rx_beat == 6), "R7 eop_out position", eop_out, rx_beat == 6);
                rx_bits = {rx_bits[11:0], data_out};
                rx_beat++;
                if (rx_beat == 7) begin
                    chk(rx_bits[13:8] == exp_msg[rx_pkts], "R1 message pass-through",
                        rx_bits[13:8], exp_msg[rx_pkts]);
                    chk(rx_bits[7:0] == exp_par[rx_pkts], "R2 R10 parity",
                        rx_bits[7:0], exp_par[rx_pkts]);
                    chk(cw_rem(rx_bits) == 8'h00, "R2 codeword divisible by g", cw_rem(rx_bits), 0);
                    rx_beat = 0;
                    rx_pkts++;
                end
            end
        end
    end

    // caller is at a sample point (falling edge + 5 ns); returns at one
    task automatic send_pkt(input logic [5:0] m, input logic [8:0] tbl, input bit gaps);
        bit acc;
        exp_msg[tx_pkts] = m;
        // R10: parity of shortened code = full (15,7) code with a leading zero
        exp_par[tx_pkts] = tbl[8] ? tbl[7:0] : ref_rem({1'b0, m});
        tx_pkts++;
        for (int b = 0; b < 3; b++) begin
            if (gaps) begin
                while (($urandom % 3) == 0) begin
                    load = 1'b0;
                    @(negedge clk); #5;
                end
            end
            load = 1'b1; sop_in = (b == 0); eop_in = (b == 2);
            data_in = m[5 - 2*b -: 2];
            acc = 1'b0;
            while (!acc) begin
                acc = (b < 2) ? ready : (!valid_out || sink_ready);
                if (!acc) begin @(negedge clk); #5; end
            end
            @(negedge clk); #5;
            load = 1'b0; sop_in = 1'b0; eop_in = 1'b0;
            // R4: ready low once two of the three beats are in
            if (b == 1) chk(!ready, "R4 ready low before final beat", ready, 0);
        end
    endtask

    task automatic wait_drain();
        int t;
        t = 0;
        while (rx_pkts != tx_pkts && t < 2000) begin @(negedge clk); #5; t++; end
        chk(rx_pkts == tx_pkts, "R1 all codewords delivered", rx_pkts, tx_pkts);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        // R11 / R9: state under reset
        chk(!valid_out, "R11 valid_out low in reset", valid_out, 0);
        @(negedge clk); rst = 1'b0; #5;
        chk(ready, "R11 ready high after reset", ready, 1);
        chk(!valid_out, "R9 idle valid_out low", valid_out, 0);

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            stall_en = VEC_MODE[v][1];
            send_pkt(VEC_MSG[v], VEC_PAR[v], VEC_MODE[v][0]);
        end
        wait_drain();

        // R5 / R6: junk load during parity phase, count ready-low cycles
        stall_en = 1'b0;
        repeat (3) begin @(negedge clk); #5; end
        send_pkt(6'h2D, 9'h000, 1'b0);
        // send_pkt returns one sample after the final beat was taken
        load = 1'b1; sop_in = 1'b1; eop_in = 1'b1; data_in = 2'b11;
        chk(!ready, "R6 ready low parity cycle 1", ready, 0);
        for (int i = 2; i <= 4; i++) begin
            @(negedge clk); #5;
            chk(!ready, "R5 R6 ready low during parity", ready, 0);
            if (i == 4) begin load = 1'b0; sop_in = 1'b0; eop_in = 1'b0; end
        end
        @(negedge clk); #5;
        chk(ready, "R6 ready back after parity", ready, 1);
        send_pkt(6'h01, 9'h1D1, 1'b0);
        wait_drain();
        repeat (2) begin @(negedge clk); #5; end
        chk(!valid_out, "R9 valid_out low when drained", valid_out, 0);

        // R3: back-to-back packets, second independent of first
        send_pkt(6'h3F, 9'h000, 1'b0);
        send_pkt(6'h02, 9'h173, 1'b0);
        wait_drain();

        // R11: reset in the middle of a packet
        load = 1'b1; sop_in = 1'b1; data_in = 2'b10;
        @(negedge clk); #5;
        data_in = 2'b01; sop_in = 1'b0;
        @(negedge clk); #5;
        load = 1'b0; rst = 1'b1;
        repeat (2) begin @(negedge clk); #5; end
        chk(!valid_out, "R11 mid-packet reset clears output", valid_out, 0);
        rst = 1'b0;
        @(negedge clk); #5;
        tx_pkts = rx_pkts;
        chk(ready, "R11 ready after mid-packet reset", ready, 1);
        send_pkt(6'h04, 9'h1E6, 1'b0);
        wait_drain();

        // random traffic with gaps and stalls
        stall_en = 1'b1;
        for (int i = 0; i < 30; i++) begin
            send_pkt(6'($urandom), 9'h000, 1'b1);
        end
        wait_drain();
        stall_en = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule